// File: doc/BRIEF.md
# PCM Serial Receive Port

This block takes 8-bit PCM voice samples from a three-wire serial link made of a bit clock, a frame sync and a data line. It turns each sample into a parallel byte. The three line inputs are asynchronous to the block. They are resynchronised into a free-running system clock, which must run at least eight times faster than the fastest bit clock, and every edge is detected in that domain. Supported bit-clock rates run from 64 kHz up to 2048 kHz.

A rising edge on the frame sync marks the most significant bit of a sample. Bits are taken on bit-clock falling edges. After eight bits the byte is placed on a parallel output together with a one-cycle valid strobe. Bit-clock edges after the eighth bit are ignored until the next sync, so frames that are wider than eight bits still deliver a clean sample.

The block also watches the bit clock. If the bit clock holds at either level for a programmable number of system-clock cycles, a power-save output is raised. That output drops again on the next bit-clock edge. Framing then resumes only at the following sync rising edge.

Top module: `pcm_rx_port`

## Requirements
- R1: While rst_ni is low and immediately after it is released, word_o reads 0, word_valid_o is 0 and psave_o is 0.
- R2: Data bits are sampled at bit-clock falling edges, most significant bit first. Bit 7 of word_o is the first bit after the sync rising edge, and bit 0 is the eighth.
- R3: A sync rising edge marks the start of a sample. If it falls in the same system-clock cycle as a bit-clock falling edge, the bit on that falling edge is taken as the most significant bit.
- R4: A sync rising edge in the middle of a frame discards the partly received bits and restarts the bit count. Only the bits after the new sync form the next byte.
- R5: Bit-clock falling edges after the eighth bit of a frame, and all falling edges before the first sync, produce no output and do not change word_o.
- R6: word_o keeps its value from one completed sample until the next one.
- R7: psave_o rises once the bit clock has shown no edge for stall_limit_i system-clock cycles, and stays low while the bit clock toggles faster than that.
- R8: psave_o falls on the first bit-clock edge after it was raised. No byte is produced after that until a new sync rising edge starts a frame.
- R9: A bit clock held steady at logic 1 and a bit clock held steady at logic 0 both lead to psave_o being raised.
- R10: word_valid_o is high for exactly one system-clock cycle for each completed sample.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Free-running system clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bclk_i | input | 1 | Serial bit clock, asynchronous |
| fsync_i | input | 1 | Frame sync; a rising edge marks the MSB |
| sdata_i | input | 1 | Serial data line |
| stall_limit_i | input | 16 | Number of idle system-clock cycles before power-save |
| word_o | output | 8 | Last completed sample |
| word_valid_o | output | 1 | One-cycle strobe when word_o is updated |
| psave_o | output | 1 | Power-save flag, raised when the bit clock stalls |

## Verification
Two functions can land in the same system-clock cycle: the frame-start detection on the sync rising edge and the bit capture on a bit-clock falling edge. The bench provokes this by driving the sync rise and the bit-clock fall on the same system-clock edge. Both lines then pass through identical synchroniser depths. The case is judged correct when the byte that comes out has the bit present on that falling edge in its most significant position. A second overlap is the clearing of power-save by the edge that ends a stall. The bench checks that this edge clears psave_o and that no byte follows until a fresh sync arrives.

// File: rtl/pcm_rx_pkg.sv
package pcm_rx_pkg;
  // line order inside the synchroniser vector
  localparam int LINE_N   = 3;
  localparam int L_BCLK   = 2;
  localparam int L_FSYNC  = 1;
  localparam int L_SDATA  = 0;

  function automatic int cnt_bits(input int n);
    return $clog2(n + 1);
  endfunction
endpackage

// File: rtl/pcm_rx_sync.sv
module pcm_rx_sync #(
  parameter int N      = 3,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] async_i,
  output logic [N-1:0] level_o,
  output logic [N-1:0] rise_o,
  output logic [N-1:0] fall_o
);
  logic [N-1:0] pipe_q [STAGES];
  logic [N-1:0] prev_q;

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) pipe_q[s] <= '0;
        else         pipe_q[s] <= async_i;
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) pipe_q[s] <= '0;
        else         pipe_q[s] <= pipe_q[s-1];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) prev_q <= '0;
    else         prev_q <= pipe_q[STAGES-1];

  assign level_o = pipe_q[STAGES-1];
  assign rise_o  = pipe_q[STAGES-1] & ~prev_q;
  assign fall_o  = ~pipe_q[STAGES-1] & prev_q;
endmodule

// File: rtl/pcm_rx_deser.sv
module pcm_rx_deser #(
  parameter int WORD_W = 8,
  localparam int CNT_W = pcm_rx_pkg::cnt_bits(WORD_W)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              frame_start_i,
  input  logic              bit_strobe_i,
  input  logic              bit_i,
  input  logic              halt_i,
  output logic [WORD_W-1:0] word_o,
  output logic              valid_o,
  output logic [CNT_W-1:0]  count_o
);
  logic [WORD_W-1:0] shreg_q, word_q;
  logic [WORD_W-1:0] shreg_nx;
  logic [CNT_W-1:0]  cnt_q;
  logic              armed_q, valid_q;

  assign shreg_nx = {shreg_q[WORD_W-2:0], bit_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      shreg_q <= '0;
      word_q  <= '0;
      cnt_q   <= '0;
      armed_q <= 1'b0;
      valid_q <= 1'b0;
    end else begin
      valid_q <= 1'b0;
      if (halt_i) begin
        armed_q <= 1'b0;
      end else if (frame_start_i) begin
        armed_q <= 1'b1;
        // sync and first falling edge in the same cycle: that bit is the MSB
        if (bit_strobe_i) begin
          shreg_q <= shreg_nx;
          cnt_q   <= CNT_W'(1);
        end else begin
          cnt_q   <= '0;
        end
      end else if (armed_q && bit_strobe_i) begin
        shreg_q <= shreg_nx;
        cnt_q   <= cnt_q + CNT_W'(1);
        if (cnt_q == CNT_W'(WORD_W - 1)) begin
          word_q  <= shreg_nx;
          valid_q <= 1'b1;
          armed_q <= 1'b0;
        end
      end
    end
  end

  assign word_o  = word_q;
  assign valid_o = valid_q;
  assign count_o = cnt_q;
endmodule

// File: rtl/pcm_rx_stall.sv
module pcm_rx_stall #(
  parameter int LIMIT_W = 16
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               edge_i,
  input  logic [LIMIT_W-1:0] limit_i,
  output logic               stall_o
);
  logic [LIMIT_W-1:0] idle_q;
  logic               stall_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idle_q  <= '0;
      stall_q <= 1'b0;
    end else if (edge_i) begin
      idle_q  <= '0;
      stall_q <= 1'b0;
    end else begin
      if (idle_q != '1) idle_q <= idle_q + LIMIT_W'(1);
      if (idle_q >= limit_i) stall_q <= 1'b1;
    end
  end

  assign stall_o = stall_q;
endmodule

// File: rtl/pcm_rx_port.sv
module pcm_rx_port #(
  parameter int WORD_W      = 8,
  parameter int SYNC_STAGES = 2,
  parameter int LIMIT_W     = 16
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               bclk_i,
  input  logic               fsync_i,
  input  logic               sdata_i,
  input  logic [LIMIT_W-1:0] stall_limit_i,
  output logic [WORD_W-1:0]  word_o,
  output logic               word_valid_o,
  output logic               psave_o
);
  import pcm_rx_pkg::*;
  localparam int CNT_W = cnt_bits(WORD_W);

  logic [LINE_N-1:0] lines, level, rise, fall;
  logic              bclk_fall, bclk_any, sync_rise;
  logic [CNT_W-1:0]  bit_count;

  always_comb begin
    lines          = '0;
    lines[L_BCLK]  = bclk_i;
    lines[L_FSYNC] = fsync_i;
    lines[L_SDATA] = sdata_i;
  end

  pcm_rx_sync #(.N(LINE_N), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .async_i(lines),
    .level_o(level), .rise_o(rise), .fall_o(fall)
  );

  assign bclk_fall = fall[L_BCLK];
  assign bclk_any  = rise[L_BCLK] | fall[L_BCLK];
  assign sync_rise = rise[L_FSYNC];

  pcm_rx_deser #(.WORD_W(WORD_W)) u_deser (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .frame_start_i(sync_rise), .bit_strobe_i(bclk_fall), .bit_i(level[L_SDATA]),
    .halt_i(psave_o), .word_o(word_o), .valid_o(word_valid_o), .count_o(bit_count)
  );

  pcm_rx_stall #(.LIMIT_W(LIMIT_W)) u_stall (
    .clk_i(clk_i), .rst_ni(rst_ni), .edge_i(bclk_any),
    .limit_i(stall_limit_i), .stall_o(psave_o)
  );
endmodule

// File: rtl/pcm_rx_port_chk.sv
module pcm_rx_port_chk #(
  parameter int WORD_W = 8,
  parameter int CNT_W  = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [WORD_W-1:0] word_o,
  input logic              word_valid_o,
  input logic              psave_o,
  input logic              bclk_edge,
  input logic [CNT_W-1:0]  bit_count
);
  // R10
  valid_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    word_valid_o |=> !word_valid_o);
  // R6
  word_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !word_valid_o |-> $stable(word_o));
  // R7
  psave_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(psave_o) |-> !$past(bclk_edge));
  // R8
  psave_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(psave_o) |-> $past(bclk_edge));
  // R8
  psave_no_word_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    psave_o |-> !word_valid_o);
  // R5
  count_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bit_count <= CNT_W'(WORD_W));
endmodule

bind pcm_rx_port pcm_rx_port_chk #(.WORD_W(WORD_W), .CNT_W(CNT_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .word_o(word_o), .word_valid_o(word_valid_o),
  .psave_o(psave_o), .bclk_edge(bclk_any), .bit_count(bit_count)
);

// File: tb/tb_pcm_rx_port.sv
module tb_pcm_rx_port;
  localparam int HALF  = 8;
  localparam int LIMIT = 40;

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       bclk = 1'b1, fsync = 1'b0, sdata = 1'b0;
  logic [15:0] limit = 16'(LIMIT);
  logic [7:0] word;
  logic       valid, psave;

  int n_chk = 0, n_fail = 0, cyc = 0;
  logic [7:0] exp_q[$];
  bit   done = 1'b0;

  always #2 clk = ~clk;

  pcm_rx_port dut (
    .clk_i(clk), .rst_ni(rst_ni), .bclk_i(bclk), .fsync_i(fsync), .sdata_i(sdata),
    .stall_limit_i(limit), .word_o(word), .word_valid_o(valid), .psave_o(psave)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // one bit period: data changes with the bit-clock rise, sampled on its fall
  task automatic send_bit(input logic b, input logic fs);
    bclk = 1'b1; sdata = b; fsync = fs;
    wait_n(HALF);
    bclk = 1'b0;
    wait_n(HALF);
  endtask

  task automatic frame(input logic [7:0] v, input int nbits);
    exp_q.push_back(v);
    for (int i = 0; i < nbits; i++)
      send_bit(i < 8 ? v[7-i] : ~v[i%8], i == 0);
  endtask

  // monitor: pop and compare each produced byte
  bit prev_valid = 1'b0;
  always @(negedge clk) begin
    cyc++;
    if (rst_ni) begin
      if (prev_valid) check(!valid, "R10 valid width", valid, 0);
      if (valid) begin
        if (exp_q.size() == 0) check(0, "R5 unexpected word", word, 0);
        else begin
          automatic logic [7:0] e = exp_q.pop_front();
          check(word == e, "R2 word", word, e);
        end
      end
      prev_valid = valid;
    end
  end

  task automatic finish_run();
    check(exp_q.size() == 0, "R2 missing words", exp_q.size(), 0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    wait_n(150000);
    if (!done) begin
      check(0, "watchdog", cyc, 0);
      finish_run();
    end
  end

  initial begin
    wait_n(3);
    check(word == 0, "R1 word", word, 0);
    check(!valid, "R1 valid", valid, 0);
    check(!psave, "R1 psave", psave, 0);
    rst_ni = 1'b1;
    wait_n(2);
    check(word == 0 && !valid && !psave, "R1 after release", {word, valid, psave}, 0);

    // R5: falling edges before any sync give nothing
    for (int i = 0; i < 10; i++) send_bit(i[0], 1'b0);
    check(word == 0, "R5 pre-sync", word, 0);

    // R2 plain frames
    frame(8'hA5, 8);
    for (int i = 0; i < 3; i++) send_bit(1'b1, 1'b0);
    frame(8'h3C, 8);
    for (int i = 0; i < 3; i++) send_bit(1'b0, 1'b0);
    check(word == 8'h3C, "R6 hold", word, 8'h3C);

    // R5 wide frame: bits after the eighth ignored
    frame(8'h96, 32);
    check(word == 8'h96, "R5 wide frame", word, 8'h96);
    check(!psave, "R7 no stall while toggling", psave, 0);

    // R4 restart in mid frame
    for (int i = 0; i < 5; i++) send_bit(1'b1, i == 0);
    frame(8'h12, 8);

    // R3 sync rise coincident with bit-clock fall
    bclk = 1'b1; sdata = 1'b1; fsync = 1'b0;
    wait_n(HALF);
    bclk = 1'b0; fsync = 1'b1;
    wait_n(HALF);
    exp_q.push_back(8'hC3);
    for (int i = 1; i < 8; i++) send_bit(8'hC3 >> (7 - i), 1'b1);
    fsync = 1'b0;
    check(word == 8'hC3, "R3 coincident MSB", word, 8'hC3);

    // R9 / R7: bit clock held high
    bclk = 1'b1;
    wait_n(LIMIT - 10);
    check(!psave, "R7 before limit", psave, 0);
    wait_n(20);
    check(psave, "R9 held high", psave, 1);
    // R8: first edge clears; no word without sync
    bclk = 1'b0;
    wait_n(8);
    check(!psave, "R8 clear on edge", psave, 0);
    for (int i = 0; i < 8; i++) send_bit(1'b1, 1'b0);
    check(word == 8'hC3, "R8 no word without sync", word, 8'hC3);

    // R9: bit clock held low
    bclk = 1'b0;
    wait_n(LIMIT + 10);
    check(psave, "R9 held low", psave, 1);
    for (int i = 0; i < 8; i++) send_bit(1'b0, 1'b0);
    check(!psave, "R8 clear after low stall", psave, 0);
    frame(8'h5A, 8);
    wait_n(4);
    check(word == 8'h5A, "R8 frame after sync", word, 8'h5A);

    done = 1'b1;
    finish_run();
  end
endmodule